// File: doc/BRIEF.md
# Six-Digit Multiplexed Display Scanner

This block keeps a six-digit BCD display register and presents it one digit at a time, in a fixed order from the most significant digit down to the least significant. A hold input decides whether the register tracks a 24-bit BCD bus from a neighbouring decade counter or keeps its current value. A scan tick moves a three-bit Johnson counter through six states. Each state selects one digit: the block raises that digit's strobe and drives the digit's BCD code and its seven-segment pattern.

Every accepted tick opens a dark gap of a programmable number of clocks. During the gap all strobes and segments are off, and the BCD output has already moved to the next digit. A force input, active low, pins the scan to the top digit and keeps the segments dark. The block also loads the counter one digit at a time. A load request is remembered until the next digit is lit. When that digit's tick ends its slot, the block issues a one-cycle write strobe that carries the digit position and the BCD input value sampled at that point.

Top module: `disp_scan`

## Requirements
- R1: While `store_hold` is low, the displayed register takes `count_bus` on every clock. Digit k is bits [4k+3:4k], and digit 5 is the most significant. `bcd_out` shows the selected digit's value one clock after the bus changes.
- R2: While `store_hold` is high, the register keeps its value and the display shows the kept value, whatever `count_bus` does.
- R3: After synchronous reset, `digit_strobe` is 6'b100000 (bit 5 = most significant digit), and `bcd_out` and `seg_out` are zero.
- R4: Each accepted tick moves the scan to the next lower digit, and digit 0 wraps to digit 5. One strobe bit marks the lit digit.
- R5: An accepted tick starts a dark gap of BLANK_CLKS clocks, beginning one clock after the tick is sampled. During the gap `digit_strobe` and `seg_out` are zero and `bcd_out` already carries the next digit's value.
- R6: A tick that arrives during the dark gap has no effect on the scan position or on the gap length.
- R7: While `force_msd_n` is low, digit 5's strobe is on, `seg_out` is zero, `bcd_out` shows digit 5, and ticks are ignored. After release, the next tick moves the scan to digit 4.
- R8: `seg_out` is active high with bit 6 = a down to bit 0 = g. Codes 0 to 9 give 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R9: A digit code from 10 to 15 gives an all-zero `seg_out`, while `bcd_out` still shows the code.
- R10: A `load_req` pulse is remembered and is bound to the next digit whose strobe turns on. On the tick that ends that digit's slot, `load_we` pulses for one clock, `load_sel` is the one-hot position of that digit and `load_val` is `bcd_in` sampled with that tick.
- R11: A request dropped after one clock still produces its load. With `load_req` held high, one full scan writes each of the six digits once.
- R12: At most one bit of `digit_strobe` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| count_bus | input | 24 | BCD value from the decade counter, six digits |
| store_hold | input | 1 | High: keep the display register |
| scan_tick | input | 1 | One-clock pulse that advances the scan |
| force_msd_n | input | 1 | Low: pin the scan to the top digit, segments dark |
| load_req | input | 1 | Request to load the next lit digit |
| bcd_in | input | 4 | BCD data for loads |
| digit_strobe | output | 6 | One-hot lit digit, bit 5 = most significant |
| bcd_out | output | 4 | BCD value of the selected digit |
| seg_out | output | 7 | Segments a..g, active high |
| load_we | output | 1 | One-clock write strobe to the counter |
| load_sel | output | 6 | One-hot digit to be written |
| load_val | output | 4 | BCD value to be written |

## Verification
A table of bus values is scanned in full. The table mixes distinct digits, a tracking entry followed by a held one with a changed bus, and codes above nine. Together these separate a wrong digit order, a display that leaks through during hold, and a decoder that lights invalid codes. Each scan step also measures the dark gap clock by clock and confirms that the BCD output changes at the gap's start. Directed runs then apply a second tick inside the gap, a hold on the force input with ticks present, a one-clock load request, and a request held through a whole scan. These show whether the request binds to the following digit rather than to the current one, and whether every position is written exactly once.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  // segments a..g on bits 6..0, active high; codes above nine stay dark
  function automatic logic [SEG_W-1:0] seg_encode(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h7E;
      4'd1: s = 7'h30;
      4'd2: s = 7'h6D;
      4'd3: s = 7'h79;
      4'd4: s = 7'h33;
      4'd5: s = 7'h5B;
      4'd6: s = 7'h5F;
      4'd7: s = 7'h70;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h7B;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int NDIG       = 6,
  parameter int BLANK_CLKS = 4,
  localparam int JW = NDIG / 2,
  localparam int IW = $clog2(NDIG),
  localparam int CW = $clog2(BLANK_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_tick,
  input  logic          force_msd_n,
  output logic          tick_acc,
  output logic          rise_ev,
  output logic          blank_nx,
  output logic [IW-1:0] idx_cur,
  output logic [IW-1:0] idx_nx
);
  logic [JW-1:0] js, js_nx;
  logic [CW-1:0] blank_cnt, cnt_nx;

  // Johnson state -> digit index (state 0 is the top digit)
  function automatic logic [IW-1:0] pos_of(input logic [JW-1:0] q);
    int c;
    int k;
    c = $countones(q);
    if (q[0] || (q == '0)) k = c;
    else k = 2 * JW - c;
    return IW'(NDIG - 1 - k);
  endfunction

  assign tick_acc = force_msd_n && scan_tick && (blank_cnt == '0);
  assign rise_ev  = force_msd_n && (blank_cnt == CW'(1));

  always_comb begin
    if (!force_msd_n) begin
      js_nx  = '0;
      cnt_nx = '0;
    end else if (tick_acc) begin
      js_nx  = {js[JW-2:0], ~js[JW-1]};
      cnt_nx = CW'(BLANK_CLKS);
    end else begin
      js_nx  = js;
      cnt_nx = (blank_cnt != '0) ? blank_cnt - CW'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      js        <= '0;
      blank_cnt <= '0;
    end else begin
      js        <= js_nx;
      blank_cnt <= cnt_nx;
    end
  end

  assign blank_nx = (cnt_nx != '0);
  assign idx_cur  = pos_of(js);
  assign idx_nx   = pos_of(js_nx);

  AST_TICK_OPENS_GAP: assert property (@(posedge clk) disable iff (rst)
    tick_acc |=> (blank_cnt == CW'(BLANK_CLKS))); // R5
  AST_GAP_IGNORES_TICK: assert property (@(posedge clk) disable iff (rst)
    (force_msd_n && (blank_cnt != '0)) |=> $stable(js)); // R6
  AST_FORCE_TOP: assert property (@(posedge clk) disable iff (rst)
    !force_msd_n |=> (js == '0)); // R7
endmodule

// File: rtl/disp_latch.sv
module disp_latch
  import disp_scan_pkg::*;
#(
  parameter int NDIG = 6,
  localparam int IW    = $clog2(NDIG),
  localparam int BUS_W = NDIG * BCD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] count_bus,
  input  logic             store_hold,
  input  logic [IW-1:0]    sel_idx,
  output logic [BCD_W-1:0] digit_val
);
  logic [BUS_W-1:0] latch_q, latch_nx;

  assign latch_nx  = store_hold ? latch_q : count_bus;
  assign digit_val = latch_nx[sel_idx*BCD_W +: BCD_W];

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= latch_nx;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    store_hold |=> $stable(latch_q)); // R2
endmodule

// File: rtl/load_ctl.sv
module load_ctl
  import disp_scan_pkg::*;
#(
  parameter int NDIG = 6,
  localparam int IW = $clog2(NDIG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_req,
  input  logic             rise_ev,
  input  logic             tick_acc,
  input  logic [IW-1:0]    idx_cur,
  input  logic [BCD_W-1:0] bcd_in,
  output logic             load_we,
  output logic [NDIG-1:0]  load_sel,
  output logic [BCD_W-1:0] load_val
);
  logic pend, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      armed    <= 1'b0;
      load_we  <= 1'b0;
      load_sel <= '0;
      load_val <= '0;
    end else begin
      pend <= rise_ev ? 1'b0 : (pend | load_req);
      if (rise_ev)       armed <= pend | load_req;
      else if (tick_acc) armed <= 1'b0;
      load_we  <= armed & tick_acc;
      load_sel <= NDIG'(1) << idx_cur;
      load_val <= bcd_in;
    end
  end

  AST_LOAD_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    load_we |-> ($countones(load_sel) == 1)); // R10
  AST_LOAD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    load_we |=> !load_we); // R10
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_scan_pkg::*;
#(
  parameter int NDIG       = 6,
  parameter int BLANK_CLKS = 4,
  localparam int IW    = $clog2(NDIG),
  localparam int BUS_W = NDIG * BCD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] count_bus,
  input  logic             store_hold,
  input  logic             scan_tick,
  input  logic             force_msd_n,
  input  logic             load_req,
  input  logic [BCD_W-1:0] bcd_in,
  output logic [NDIG-1:0]  digit_strobe,
  output logic [BCD_W-1:0] bcd_out,
  output logic [SEG_W-1:0] seg_out,
  output logic             load_we,
  output logic [NDIG-1:0]  load_sel,
  output logic [BCD_W-1:0] load_val
);
  logic             tick_acc, rise_ev, blank_nx;
  logic [IW-1:0]    idx_cur, idx_nx;
  logic [BCD_W-1:0] digit_val;

  scan_seq #(.NDIG(NDIG), .BLANK_CLKS(BLANK_CLKS)) u_seq (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .force_msd_n(force_msd_n),
    .tick_acc(tick_acc), .rise_ev(rise_ev), .blank_nx(blank_nx),
    .idx_cur(idx_cur), .idx_nx(idx_nx)
  );

  disp_latch #(.NDIG(NDIG)) u_lat (
    .clk(clk), .rst(rst), .count_bus(count_bus), .store_hold(store_hold),
    .sel_idx(idx_nx), .digit_val(digit_val)
  );

  load_ctl #(.NDIG(NDIG)) u_ld (
    .clk(clk), .rst(rst), .load_req(load_req), .rise_ev(rise_ev),
    .tick_acc(tick_acc), .idx_cur(idx_cur), .bcd_in(bcd_in),
    .load_we(load_we), .load_sel(load_sel), .load_val(load_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_strobe <= NDIG'(1) << (NDIG - 1);
      bcd_out      <= '0;
      seg_out      <= '0;
    end else begin
      digit_strobe <= blank_nx ? '0 : (NDIG'(1) << idx_nx);
      bcd_out      <= digit_val;
      seg_out      <= (blank_nx || !force_msd_n) ? '0 : seg_encode(digit_val);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_strobe)); // R12
  AST_DARK_WHEN_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (digit_strobe == '0) |-> (seg_out == '0)); // R5
  AST_FORCE_DARK_TOP: assert property (@(posedge clk) disable iff (rst)
    !force_msd_n |=> ((seg_out == '0) && digit_strobe[NDIG-1])); // R7
endmodule

// File: tb/sim_disp_scan.sv
module sim_disp_scan;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 6;
  localparam int BLK  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] count_bus = '0;
  logic        store_hold = 1'b0;
  logic        scan_tick = 1'b0;
  logic        force_msd_n = 1'b1;
  logic        load_req = 1'b0;
  logic [3:0]  bcd_in = '0;
  logic [5:0]  digit_strobe;
  logic [3:0]  bcd_out;
  logic [6:0]  seg_out;
  logic        load_we;
  logic [5:0]  load_sel;
  logic [3:0]  load_val;

  int n_cmp = 0;
  int n_bad = 0;
  int cur = 5;
  logic [23:0] model = '0;
  bit done = 0;

  localparam logic [24:0] VEC [6] = '{
    {24'h123456, 1'b0}, {24'h987650, 1'b0}, {24'h111111, 1'b1},
    {24'hFA9070, 1'b0}, {24'h000000, 1'b1}, {24'h246813, 1'b0}};

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_scan #(.NDIG(NDIG), .BLANK_CLKS(BLK)) u0 (
    .clk(clk), .rst(rst), .count_bus(count_bus), .store_hold(store_hold),
    .scan_tick(scan_tick), .force_msd_n(force_msd_n), .load_req(load_req),
    .bcd_in(bcd_in), .digit_strobe(digit_strobe), .bcd_out(bcd_out),
    .seg_out(seg_out), .load_we(load_we), .load_sel(load_sel),
    .load_val(load_val)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    case (v)
      4'd0: return 7'h7E; 4'd1: return 7'h30; 4'd2: return 7'h6D;
      4'd3: return 7'h79; 4'd4: return 7'h33; 4'd5: return 7'h5B;
      4'd6: return 7'h5F; 4'd7: return 7'h70; 4'd8: return 7'h7F;
      4'd9: return 7'h7B; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [3:0] dig(input int i);
    return model[i*4 +: 4];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    scan_tick = 1'b1;
    @(negedge clk);
    scan_tick = 1'b0;
  endtask

  // one scan step: tick, measure gap, check the next digit and any load
  task automatic step(input bit exp_we, input int exp_sel, input logic [3:0] exp_val);
    int nxt;
    nxt = (cur == 0) ? 5 : cur - 1;
    tick();
    chk("R5 strobe dark at gap start", digit_strobe, 0);
    chk("R5 segments dark at gap start", seg_out, 0);
    chk("R5 bcd changes at gap start", bcd_out, dig(nxt));
    chk("R10 load_we", load_we, exp_we);
    if (exp_we) begin
      chk("R10 load_sel", load_sel, 6'(1) << exp_sel);
      chk("R10 load_val", load_val, exp_val);
    end
    wait_n(BLK - 1);
    chk("R5 strobe dark at gap end", digit_strobe, 0);
    wait_n(1);
    chk("R4 strobe order", digit_strobe, 6'(1) << nxt);
    chk("R1 bcd value", bcd_out, dig(nxt));
    chk("R8 R9 segment pattern", seg_out, exp_seg(dig(nxt)));
    cur = nxt;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R3 reset strobe", digit_strobe, 6'b100000);
    chk("R3 reset bcd", bcd_out, 0);
    chk("R3 reset seg", seg_out, 0);

    rst = 1'b0;
    count_bus = 24'h123456;
    model = 24'h123456;
    wait_n(1);
    chk("R1 top digit after reset", bcd_out, 4'd1);
    chk("R8 top digit segments", seg_out, exp_seg(4'd1));

    // table walk: each entry scans all six digits
    for (int e = 0; e < 6; e++) begin
      count_bus  = VEC[e][24:1];
      store_hold = VEC[e][0];
      if (!VEC[e][0]) model = VEC[e][24:1];
      wait_n(1);
      chk("R1 R2 shown digit after bus change", bcd_out, dig(cur));
      for (int s = 0; s < 6; s++) step(0, 0, 0);
    end
    store_hold = 1'b0;
    count_bus  = 24'h3C5917;
    model      = 24'h3C5917;
    wait_n(1);

    // R6: second tick inside the gap
    begin
      int nxt;
      nxt = (cur == 0) ? 5 : cur - 1;
      tick();
      tick();
      wait_n(1);
      chk("R6 still dark", digit_strobe, 0);
      wait_n(1);
      chk("R6 single advance", digit_strobe, 6'(1) << nxt);
      cur = nxt;
    end

    // R7: force to top digit
    force_msd_n = 1'b0;
    wait_n(1);
    chk("R7 forced strobe", digit_strobe, 6'b100000);
    chk("R7 forced seg dark", seg_out, 0);
    chk("R7 forced bcd top", bcd_out, dig(5));
    tick();
    wait_n(1);
    chk("R7 tick ignored", digit_strobe, 6'b100000);
    chk("R7 still dark", seg_out, 0);
    force_msd_n = 1'b1;
    wait_n(1);
    chk("R7 released segments", seg_out, exp_seg(dig(5)));
    cur = 5;
    step(0, 0, 0);
    chk("R7 resume at digit 4", digit_strobe, 6'b010000);

    // R10/R11: one-clock request binds to the next lit digit
    load_req = 1'b1;
    wait_n(1);
    load_req = 1'b0;
    bcd_in = 4'd7;
    step(0, 0, 0);
    step(1, 3, 4'd7);
    wait_n(1);
    chk("R11 load pulse ends", load_we, 0);

    // R11: request held for a full scan writes each digit once
    load_req = 1'b1;
    step(0, 0, 0);
    for (int s = 0; s < 6; s++) begin
      int prev;
      prev = cur;
      bcd_in = 4'(prev + 1);
      step(1, prev, 4'(prev + 1));
    end
    load_req = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule